// File: doc/BRIEF.md
# Edge-Capture Timer with Dual Compare Outputs

The block is a 12-bit up-counter advanced by a power-of-two clock divider. Counting runs only while the capture mode enable is high. Dropping the enable returns the counter to zero. A transition on an asynchronous input pin stamps the current count into a capture register. A select input chooses whether a rising or a falling transition does this. Each stamp raises a pending flag, and each wrap of the counter raises a second pending flag. Software clears either flag by writing a one to its clear input.

The same counter also feeds two comparators. The first comparator sets a duty-cycle output each time the counter wraps and clears it when the count matches compare value A. The second comparator issues a one-clock converter strobe when the count reaches compare value B, provided the strobe enable is set.

Top module: `cap_timer`

## Requirements
- R1: With mode_en_i high, the count advances by one on each divider tick and wraps from 0xFFF to 0x000. With mode_en_i low, the count and the divider are held at zero.
- R2: A prescale value n on presc_i makes a tick every 2^n clocks. After k clock edges with the mode enabled, the count is floor(k / 2^n) mod 4096.
- R3: The tick that wraps the count from 0xFFF to 0x000 sets ovf_pend_o at that same clock edge.
- R4: A qualifying edge loads cap_val_o with the count held just before the loading clock edge.
- R5: Suppose the pin changes between clock edges j and j+1. The capture is visible after edge j+3 and is not visible after edge j+2.
- R6: When rise_sel_i is 1, only low-to-high transitions capture. When rise_sel_i is 0, only high-to-low transitions capture. A transition of the other direction leaves cap_val_o and cap_pend_o unchanged.
- R7: Every capture sets cap_pend_o.
- R8: A clock edge with cap_clr_i (or ovf_clr_i) high clears the matching pending flag. If a new event arrives at the same edge, the flag stays set.
- R9: pwm_o goes high at the edge where the count wraps to 0. It goes low at the edge after the count equals cmp_a_i. With prescale 0 this makes pwm_o high exactly while the count is 0..A, from the first wrap onward.
- R10: strobe_o is high for the first clock in which the count equals cmp_b_i, but only if strobe_en_i was high at the edge where the count reached that value.
- R11: While mode_en_i is low, pwm_o and strobe_o stay low and pin transitions cause no capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Timer clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_en_i | input | 1 | Capture mode enable; low holds the counter at zero |
| presc_i | input | 3 | Divider select, tick every 2^n clocks |
| rise_sel_i | input | 1 | 1: rising edges capture, 0: falling edges capture |
| cap_pin_i | input | 1 | Asynchronous capture input |
| cmp_a_i | input | 12 | Compare value that ends the duty-cycle high phase |
| cmp_b_i | input | 12 | Compare value that fires the strobe |
| strobe_en_i | input | 1 | Strobe enable |
| cap_clr_i | input | 1 | Write-one clear of the capture-pending flag |
| ovf_clr_i | input | 1 | Write-one clear of the overflow-pending flag |
| cap_val_o | output | 12 | Last captured count |
| cap_pend_o | output | 1 | Capture-pending flag |
| ovf_pend_o | output | 1 | Overflow-pending flag |
| pwm_o | output | 1 | Duty-cycle output |
| strobe_o | output | 1 | One-clock converter strobe |

## Verification
A pin change made between edges j and j+1 is due after edge j+3, and it must still be absent after edge j+2. The bench therefore checks the flag at both points, and it computes the expected count as floor((j+2)/2^n) for every prescale value. The overflow flag, the duty-cycle output and the strobe are all registered, so each one changes at the edge that moves the count. The bench drives and samples on falling clock edges and keeps its own edge count k since enable, which gives floor(k/2^n) mod 4096 as the count against which every output is predicted. Clears are raised half a cycle ahead of the edge they target, so the set-wins case lines up exactly with the capture edge.

// File: rtl/cap_timer_pkg.sv
package cap_timer_pkg;
  localparam int unsigned CNT_W    = 12;
  localparam int unsigned PS_W     = 3;
  localparam int unsigned SYNC_LEN = 2;

  typedef enum logic {
    EDGE_FALL = 1'b0,
    EDGE_RISE = 1'b1
  } edge_sel_e;
endpackage

// File: rtl/ctm_prescaler.sv
module ctm_prescaler #(
  parameter int unsigned PS_W = cap_timer_pkg::PS_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            run_i,
  input  logic [PS_W-1:0] presc_i,
  output logic            tick_o
);
  localparam int unsigned DIV_W = (1 << PS_W) - 1;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] mask;

  assign mask   = ~({DIV_W{1'b1}} << presc_i);
  assign tick_o = run_i && ((div_q & mask) == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     div_q <= '0;
    else if (!run_i) div_q <= '0;
    else             div_q <= div_q + 1'b1;
  end

  // with a nonzero divider two ticks never fall on adjacent clocks
  AST_TICK_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o && (presc_i != '0) |=> !tick_o || (presc_i == '0)); // R2
endmodule

// File: rtl/ctm_edge_sync.sv
module ctm_edge_sync #(
  parameter int unsigned STAGES = cap_timer_pkg::SYNC_LEN
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic rise_i,
  output logic edge_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;
  logic              lvl;

  assign lvl = sync_q[STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin_i};
      last_q <= lvl;
    end
  end

  assign edge_o = rise_i ? (lvl & ~last_q) : (~lvl & last_q);

  // one polarity cannot repeat on adjacent clocks
  AST_EDGE_SPACED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_o && $stable(rise_i) |=> !edge_o || (rise_i != $past(rise_i))); // R6
endmodule

// File: rtl/ctm_counter.sv
module ctm_counter #(
  parameter int unsigned CNT_W = cap_timer_pkg::CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cnt_nxt_o,
  output logic             wrap_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;

  assign cnt_nxt_o = cnt_q + 1'b1;
  assign wrap_o    = tick_i && (cnt_q == CNT_MAX);
  assign cnt_o     = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (tick_i)  cnt_q <= cnt_nxt_o;
  end

  AST_CNT_ROLL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && tick_i && (cnt_q == CNT_MAX) |=> cnt_q == '0); // R1
  AST_CNT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> cnt_q == '0); // R1
  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && !tick_i |=> $stable(cnt_q)); // R2
endmodule

// File: rtl/cap_timer.sv
module cap_timer
  import cap_timer_pkg::*;
#(
  parameter int unsigned CW  = CNT_W,
  parameter int unsigned PW  = PS_W,
  parameter int unsigned SYN = SYNC_LEN
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mode_en_i,
  input  logic [PW-1:0] presc_i,
  input  logic          rise_sel_i,
  input  logic          cap_pin_i,
  input  logic [CW-1:0] cmp_a_i,
  input  logic [CW-1:0] cmp_b_i,
  input  logic          strobe_en_i,
  input  logic          cap_clr_i,
  input  logic          ovf_clr_i,
  output logic [CW-1:0] cap_val_o,
  output logic          cap_pend_o,
  output logic          ovf_pend_o,
  output logic          pwm_o,
  output logic          strobe_o
);
  logic          tick;
  logic          wrap;
  logic          pin_edge;
  logic          cap_evt;
  logic [CW-1:0] cnt;
  logic [CW-1:0] cnt_nxt;
  logic [CW-1:0] cap_q;
  logic          cap_pend_q, ovf_pend_q, pwm_q, strobe_q;
  edge_sel_e     esel;

  assign esel = edge_sel_e'(rise_sel_i);

  ctm_prescaler #(.PS_W(PW)) u_presc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (mode_en_i),
    .presc_i (presc_i),
    .tick_o  (tick)
  );

  ctm_counter #(.CNT_W(CW)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (mode_en_i),
    .tick_i    (tick),
    .cnt_o     (cnt),
    .cnt_nxt_o (cnt_nxt),
    .wrap_o    (wrap)
  );

  ctm_edge_sync #(.STAGES(SYN)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (cap_pin_i),
    .rise_i (esel == EDGE_RISE),
    .edge_o (pin_edge)
  );

  assign cap_evt = mode_en_i && pin_edge;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_q      <= '0;
      cap_pend_q <= 1'b0;
      ovf_pend_q <= 1'b0;
    end else begin
      if (cap_evt) cap_q <= cnt;
      // new event beats a same-cycle clear
      if (cap_evt)        cap_pend_q <= 1'b1;
      else if (cap_clr_i) cap_pend_q <= 1'b0;
      if (wrap)           ovf_pend_q <= 1'b1;
      else if (ovf_clr_i) ovf_pend_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pwm_q    <= 1'b0;
      strobe_q <= 1'b0;
    end else begin
      if (!mode_en_i)          pwm_q <= 1'b0;
      else if (wrap)           pwm_q <= 1'b1;
      else if (cnt == cmp_a_i) pwm_q <= 1'b0;
      strobe_q <= mode_en_i && strobe_en_i && tick && (cnt_nxt == cmp_b_i);
    end
  end

  assign cap_val_o  = cap_q;
  assign cap_pend_o = cap_pend_q;
  assign ovf_pend_o = ovf_pend_q;
  assign pwm_o      = pwm_q;
  assign strobe_o   = strobe_q;

  AST_CAP_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_evt |=> cap_val_o == $past(cnt)); // R4
  AST_CAP_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_evt |=> cap_pend_o); // R7
  AST_CAP_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_clr_i && !cap_evt |=> !cap_pend_o); // R8
  AST_OVF_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap |=> ovf_pend_o); // R3
  AST_PWM_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap && mode_en_i |=> pwm_o); // R9
  AST_STB_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |=> !strobe_o); // R10
  AST_OFF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_en_i |=> !pwm_o && !strobe_o); // R11
endmodule

// File: tb/cap_timer_test.sv
`timescale 1ns/1ps
module cap_timer_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        mode_en_i = 1'b0;
  logic [2:0]  presc_i = '0;
  logic        rise_sel_i = 1'b1;
  logic        cap_pin_i = 1'b0;
  logic [11:0] cmp_a_i = 12'd5;
  logic [11:0] cmp_b_i = 12'd9;
  logic        strobe_en_i = 1'b0;
  logic        cap_clr_i = 1'b0;
  logic        ovf_clr_i = 1'b0;
  logic [11:0] cap_val_o;
  logic        cap_pend_o, ovf_pend_o, pwm_o, strobe_o;

  int n_chk = 0;
  int n_bad = 0;
  int wd    = 0;

  always #5 clk_i = ~clk_i;

  cap_timer uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_en_i(mode_en_i), .presc_i(presc_i),
    .rise_sel_i(rise_sel_i), .cap_pin_i(cap_pin_i), .cmp_a_i(cmp_a_i),
    .cmp_b_i(cmp_b_i), .strobe_en_i(strobe_en_i), .cap_clr_i(cap_clr_i),
    .ovf_clr_i(ovf_clr_i), .cap_val_o(cap_val_o), .cap_pend_o(cap_pend_o),
    .ovf_pend_o(ovf_pend_o), .pwm_o(pwm_o), .strobe_o(strobe_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic clr_pend();
    @(negedge clk_i); cap_clr_i = 1'b1; ovf_clr_i = 1'b1;
    @(negedge clk_i); cap_clr_i = 1'b0; ovf_clr_i = 1'b0;
  endtask

  // returns at the negedge where k = 0
  task automatic start_mode(input int n);
    @(negedge clk_i); mode_en_i = 1'b0; presc_i = 3'(n);
    @(negedge clk_i); mode_en_i = 1'b1;
  endtask

  always @(posedge clk_i) begin
    wd++;
    if (wd > 150000) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", wd, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    step(3);
    check("reset cap_val R4", int'(cap_val_o), 0);
    check("reset cap_pend R7", int'(cap_pend_o), 0);
    check("reset ovf_pend R3", int'(ovf_pend_o), 0);
    check("reset pwm R9", int'(pwm_o), 0);
    check("reset strobe R10", int'(strobe_o), 0);
    rst_ni = 1'b1;
    step(2);

    // duty cycle, strobe, wrap at prescale 0: R1 R3 R9 R10
    strobe_en_i = 1'b1;
    start_mode(0);
    for (int k = 1; k <= 4200; k++) begin
      @(negedge clk_i);
      check("R9 pwm", int'(pwm_o), int'(k >= 4096 && (k % 4096) <= 5));
      check("R10 strobe", int'(strobe_o), int'(k <= 4100 && (k % 4096) == 9));
      check("R1 R3 wrap flag", int'(ovf_pend_o), int'(k >= 4096));
      if (k == 4100) strobe_en_i = 1'b0;
    end

    // overflow timing with divider: R2 R3
    for (int n = 1; n <= 2; n++) begin
      clr_pend();
      check("R8 ovf clear", int'(ovf_pend_o), 0);
      start_mode(n);
      step((4096 << n) - 1);
      check("R2 no wrap yet", int'(ovf_pend_o), 0);
      step(1);
      check("R2 R3 wrap", int'(ovf_pend_o), 1);
    end

    // capture sweep across every divider: R2 R4 R5 R6 R7 R8
    rise_sel_i = 1'b1;
    for (int n = 0; n < 8; n++) begin
      int j;
      j = 300 + 97 * n;
      clr_pend();
      start_mode(n);
      step(j);
      cap_pin_i = 1'b1;
      step(2);
      check("R5 not before third edge", int'(cap_pend_o), 0);
      step(1);
      check("R7 pend", int'(cap_pend_o), 1);
      check("R4 R2 value", int'(cap_val_o), ((j + 2) >> n) & 12'hFFF);
      clr_pend();
      check("R8 clear", int'(cap_pend_o), 0);
      cap_pin_i = 1'b0;
      step(4);
      check("R6 falling ignored pend", int'(cap_pend_o), 0);
      check("R6 falling ignored val", int'(cap_val_o), ((j + 2) >> n) & 12'hFFF);
    end

    // falling-edge select: R6
    rise_sel_i = 1'b0;
    start_mode(2);
    step(50);
    cap_pin_i = 1'b1;
    step(4);
    check("R6 rising ignored", int'(cap_pend_o), 0);
    step(10);
    cap_pin_i = 1'b0;
    step(3);
    check("R6 falling pend", int'(cap_pend_o), 1);
    check("R6 falling value", int'(cap_val_o), 66 >> 2);

    // set beats clear: R8
    rise_sel_i = 1'b1;
    clr_pend();
    start_mode(0);
    step(100);
    cap_pin_i = 1'b1;
    step(2);
    cap_clr_i = 1'b1;
    step(1);
    check("R8 set wins", int'(cap_pend_o), 1);
    check("R8 set wins value", int'(cap_val_o), 102);
    step(1);
    check("R8 clear after", int'(cap_pend_o), 0);
    cap_clr_i = 1'b0;

    // disabled mode: R11
    strobe_en_i = 1'b1;
    cmp_b_i = 12'd1;
    @(negedge clk_i); mode_en_i = 1'b0;
    step(2);
    cap_pin_i = 1'b0;
    step(5);
    cap_pin_i = 1'b1;
    step(5);
    check("R11 no capture", int'(cap_pend_o), 0);
    check("R11 value held", int'(cap_val_o), 102);
    check("R11 pwm low", int'(pwm_o), 0);
    check("R11 strobe low", int'(strobe_o), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule